// File: doc/BRIEF.md
# Circular Audio DMA Bridge Channel

This block moves audio samples between system memory and the FIFOs of an audio serializer for one audio unit. It has a playback direction that fetches 32-bit words from memory and pushes them into the transmit FIFO, and a record direction that takes words from the receive FIFO and stores them to memory. Each direction walks a ring buffer. It starts at a programmed base address and advances four bytes per transfer until a programmed byte count has been covered.

Software programs a base and a length for each direction and then sets the enable bit in a shared control word. The block raises an event when the progress counter crosses half of the length. It raises another when the counter reaches the full length. Software can refill one half of the buffer while the hardware drains the other. With auto-reload, the ring wraps to the base without software help. Without it, the direction stops by itself after one pass.

Each direction has its own memory request port and grant input. Arbitration between them is left to the surrounding fabric. A grant completes a word transfer in the same cycle.

Top module: `aud_ring_dma`

## Requirements
- R1: After reset every register, both progress counters and the status word read 0, no memory request is raised and `evt` is 0.
- R2: Register offsets are 0x00 playback base, 0x04 record base, 0x08 playback length, 0x0C record length, 0x10 control, 0x14 playback progress, 0x18 record progress, 0x1C status. Lengths hold 26 bits with bits 1:0 forced to 0 (writing 0xFFFFFFFF reads 0x03FFFFFC). Bases also have bits 1:0 forced to 0.
- R3: The control fields are as follows. Playback uses bit 0 for enable, bit 1 for stop, bit 2 for auto-reload and bits 9:8 for alignment mode. Record uses bit 16 for enable, bit 17 for stop, bit 18 for auto-reload and bits 25:24 for alignment mode. Alignment fields read back as written, and the stop bits always read 0.
- R4: While playback is enabled and `txf_ready` is 1, `pb_req` is high and `pb_addr` = base + progress. In a granted cycle `pb_rdata` is pushed into the transmit FIFO in that same cycle, and progress then advances by 4.
- R5: While record is enabled and `rxf_valid` is 1, `rc_req` is high, `rc_addr` = base + progress and `rc_wdata` = `rxf_data`. A grant pops the receive FIFO in that same cycle, and progress then advances by 4.
- R6: A transfer that takes progress from below length/2 to at least length/2 raises the half event. A transfer that reaches the length raises the full event. `evt` carries these as one-cycle pulses in the cycle after the transfer, with bit 0 playback half, bit 1 playback full, bit 2 record half and bit 3 record full.
- R7: With auto-reload set, reaching the length sets progress to 0, so the address returns to the base, and the direction stays enabled.
- R8: Without auto-reload, reaching the length clears that direction's enable bit and sets progress to 0, and requests stop.
- R9: Writing 1 to a stop bit clears that direction's enable and progress at once. Stop takes priority over an enable bit set in the same write.
- R10: Each event also sets the matching status bit, and writing 1 to a status bit clears it. An event in the same cycle as a clear leaves the bit set.
- R11: The two directions run independently and can raise events in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| pb_req | output | 1 | Playback memory read request |
| pb_addr | output | 32 | Playback read address |
| pb_gnt | input | 1 | Playback grant; read completes this cycle |
| pb_rdata | input | 32 | Playback read data |
| txf_ready | input | 1 | Transmit FIFO has room for a word |
| txf_push | output | 1 | Transmit FIFO push |
| txf_data | output | 32 | Transmit FIFO data |
| rc_req | output | 1 | Record memory write request |
| rc_addr | output | 32 | Record write address |
| rc_wdata | output | 32 | Record write data |
| rc_gnt | input | 1 | Record grant; write completes this cycle |
| rxf_valid | input | 1 | Receive FIFO holds a word |
| rxf_data | input | 32 | Receive FIFO head word |
| rxf_pop | output | 1 | Receive FIFO pop |
| evt | output | 4 | Event pulses: playback half, playback full, record half, record full |

## Verification
A software clear of the status word can land in the same cycle as a new half or full event. Both directions can also cross their half marks in that cycle. The bench provokes this with one edge that carries a status write of all ones together with a grant on both directions, each starting from progress 0 with length 8. It then expects status 0x5: the two fresh half events survive the clear, and the event pulse counters each grow by exactly one.

// File: rtl/aud_dma_pkg.sv
// Shared constants for the circular audio DMA bridge.
// Assumes a 5-bit byte-offset register space and two directions
// whose control fields sit 16 bits apart in the control word.
package aud_dma_pkg;
    localparam logic [4:0] OFS_PB_BASE = 5'h00;
    localparam logic [4:0] OFS_RC_BASE = 5'h04;
    localparam logic [4:0] OFS_PB_LEN  = 5'h08;
    localparam logic [4:0] OFS_RC_LEN  = 5'h0C;
    localparam logic [4:0] OFS_CTRL    = 5'h10;
    localparam logic [4:0] OFS_PB_PROG = 5'h14;
    localparam logic [4:0] OFS_RC_PROG = 5'h18;
    localparam logic [4:0] OFS_STATUS  = 5'h1C;

    localparam int DIRS       = 2;
    localparam int NEV        = 2 * DIRS;
    localparam int DIR_STRIDE = 16;
    localparam int BIT_EN     = 0;
    localparam int BIT_STOP   = 1;
    localparam int BIT_RELOAD = 2;
    localparam int BIT_ALIGN  = 8;
    localparam int BYTES_PER_BEAT = 4;

    typedef enum logic [1:0] {
        ALIGN_NONE  = 2'd0,
        ALIGN_4BYTE = 2'd1,
        ALIGN_2WORD = 2'd2,
        ALIGN_RSVD  = 2'd3
    } align_mode_e;
endpackage

// File: rtl/aud_dma_chan.sv
// Address and progress datapath of one ring direction.
// Assumes the caller asserts beat only while the direction runs,
// and that len is a multiple of 4 (bits 1:0 zero).
module aud_dma_chan
    import aud_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 26
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          beat,
    input  logic          clr,
    input  logic [AW-1:0] base,
    input  logic [CW-1:0] len,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] prog,
    output logic          hit_half,
    output logic          hit_full
);
    localparam logic [CW:0] STEP = (CW+1)'(BYTES_PER_BEAT);

    logic [CW:0] nxt;
    logic [CW:0] half_mark;
    logic [CW:0] full_mark;

    // Next progress value and the two marks, one bit wider to avoid wrap
    always_comb begin
        nxt       = {1'b0, prog} + STEP;
        half_mark = {2'b00, len[CW-1:1]};
        full_mark = {1'b0, len};
        hit_half  = beat && ({1'b0, prog} < half_mark) && (nxt >= half_mark);
        hit_full  = beat && (nxt >= full_mark);
    end

    // Progress counter: cleared by stop, wraps to 0 at the full mark
    always_ff @(posedge clk) begin
        if (!rst_n)        prog <= '0;
        else if (clr)      prog <= '0;
        else if (beat)     prog <= hit_full ? '0 : nxt[CW-1:0];
    end

    // Current word address inside the ring
    assign addr = base + AW'(prog);
endmodule

// File: rtl/aud_dma_regs.sv
// Register file: bases, lengths, shared control word and sticky status.
// Assumes AW <= 32 and CW <= 32; reads are combinational on reg_addr.
module aud_dma_regs
    import aud_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 26
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr,
    input  logic [4:0]               addr,
    input  logic [31:0]              wdata,
    output logic [31:0]              rdata,
    input  logic [DIRS-1:0][CW-1:0]  prog,
    input  logic [DIRS-1:0]          hit_half,
    input  logic [DIRS-1:0]          hit_full,
    output logic [DIRS-1:0][AW-1:0]  base,
    output logic [DIRS-1:0][CW-1:0]  len,
    output logic [DIRS-1:0]          en,
    output logic [DIRS-1:0]          auto_rl,
    output logic [DIRS-1:0]          stop,
    output logic [NEV-1:0]           status
);
    logic                      ctrl_wr;
    logic                      stat_wr;
    logic [DIRS-1:0][1:0]      align;
    logic [NEV-1:0]            ev_now;
    logic [31:0]               ctrl_img;

    assign ctrl_wr = wr && (addr == OFS_CTRL);
    assign stat_wr = wr && (addr == OFS_STATUS);

    for (genvar d = 0; d < DIRS; d++) begin : g_dir
        localparam int SH = d * DIR_STRIDE;
        localparam logic [4:0] A_BASE = (d == 0) ? OFS_PB_BASE : OFS_RC_BASE;
        localparam logic [4:0] A_LEN  = (d == 0) ? OFS_PB_LEN  : OFS_RC_LEN;

        assign stop[d]         = ctrl_wr && wdata[SH + BIT_STOP];
        assign ev_now[2*d]     = hit_half[d];
        assign ev_now[2*d + 1] = hit_full[d];

        // Base address register, word aligned
        always_ff @(posedge clk) begin
            if (!rst_n)                      base[d] <= '0;
            else if (wr && addr == A_BASE)   base[d] <= {wdata[AW-1:2], 2'b00};
        end

        // Byte length register, word multiple
        always_ff @(posedge clk) begin
            if (!rst_n)                      len[d] <= '0;
            else if (wr && addr == A_LEN)    len[d] <= {wdata[CW-1:2], 2'b00};
        end

        // Control fields: a write wins over self-clear, stop wins over enable
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en[d]      <= 1'b0;
                auto_rl[d] <= 1'b0;
                align[d]   <= ALIGN_NONE;
            end else if (ctrl_wr) begin
                en[d]      <= wdata[SH + BIT_EN] && !wdata[SH + BIT_STOP];
                auto_rl[d] <= wdata[SH + BIT_RELOAD];
                align[d]   <= wdata[SH + BIT_ALIGN +: 2];
            end else if (hit_full[d] && !auto_rl[d]) begin
                en[d]      <= 1'b0;
            end
        end
    end

    // Sticky event status, write-one-to-clear, a new event beats the clear
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= ev_now | (status & ~({NEV{stat_wr}} & wdata[NEV-1:0]));
    end

    // Readback image of the control word; stop bits read as 0
    always_comb begin
        ctrl_img = '0;
        for (int d = 0; d < DIRS; d++) begin
            ctrl_img[d*DIR_STRIDE + BIT_EN]         = en[d];
            ctrl_img[d*DIR_STRIDE + BIT_RELOAD]     = auto_rl[d];
            ctrl_img[d*DIR_STRIDE + BIT_ALIGN +: 2] = align[d];
        end
    end

    // Register read multiplexer
    always_comb begin
        case (addr)
            OFS_PB_BASE: rdata = 32'(base[0]);
            OFS_RC_BASE: rdata = 32'(base[1]);
            OFS_PB_LEN:  rdata = 32'(len[0]);
            OFS_RC_LEN:  rdata = 32'(len[1]);
            OFS_CTRL:    rdata = ctrl_img;
            OFS_PB_PROG: rdata = 32'(prog[0]);
            OFS_RC_PROG: rdata = 32'(prog[1]);
            OFS_STATUS:  rdata = 32'(status);
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/aud_ring_dma.sv
// Circular audio DMA bridge for one audio unit: playback ring from
// memory to the transmit FIFO, record ring from the receive FIFO to memory.
// Assumes a grant completes the memory access in the same cycle.
module aud_ring_dma
    import aud_dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 26,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [4:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          pb_req,
    output logic [AW-1:0] pb_addr,
    input  logic          pb_gnt,
    input  logic [DW-1:0] pb_rdata,
    input  logic          txf_ready,
    output logic          txf_push,
    output logic [DW-1:0] txf_data,
    output logic          rc_req,
    output logic [AW-1:0] rc_addr,
    output logic [DW-1:0] rc_wdata,
    input  logic          rc_gnt,
    input  logic          rxf_valid,
    input  logic [DW-1:0] rxf_data,
    output logic          rxf_pop,
    output logic [NEV-1:0] evt
);
    logic [DIRS-1:0][AW-1:0] base;
    logic [DIRS-1:0][CW-1:0] len;
    logic [DIRS-1:0][CW-1:0] prog;
    logic [DIRS-1:0][AW-1:0] addr;
    logic [DIRS-1:0]         en;
    logic [DIRS-1:0]         auto_rl;
    logic [DIRS-1:0]         stop;
    logic [DIRS-1:0]         beat;
    logic [DIRS-1:0]         hit_half;
    logic [DIRS-1:0]         hit_full;
    logic [NEV-1:0]          status;

    aud_dma_regs #(.AW(AW), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .prog(prog),
        .hit_half(hit_half), .hit_full(hit_full), .base(base), .len(len),
        .en(en), .auto_rl(auto_rl), .stop(stop), .status(status)
    );

    for (genvar d = 0; d < DIRS; d++) begin : g_chan
        aud_dma_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk(clk), .rst_n(rst_n), .beat(beat[d]), .clr(stop[d]),
            .base(base[d]), .len(len[d]), .addr(addr[d]), .prog(prog[d]),
            .hit_half(hit_half[d]), .hit_full(hit_full[d])
        );
    end

    // Playback side: fetch while the transmit FIFO has room
    assign pb_req   = en[0] && txf_ready;
    assign pb_addr  = addr[0];
    assign beat[0]  = pb_req && pb_gnt;
    assign txf_push = beat[0];
    assign txf_data = pb_rdata;

    // Record side: store while the receive FIFO holds data
    assign rc_req   = en[1] && rxf_valid;
    assign rc_addr  = addr[1];
    assign rc_wdata = rxf_data;
    assign beat[1]  = rc_req && rc_gnt;
    assign rxf_pop  = beat[1];

    // Event pulses, one cycle after the transfer that crossed a mark
    always_ff @(posedge clk) begin
        if (!rst_n) evt <= '0;
        else        evt <= {hit_full[1], hit_half[1], hit_full[0], hit_half[0]};
    end
endmodule

// File: rtl/aud_ring_dma_chk.sv
// Property checker for aud_ring_dma, attached by bind below.
// Assumes the port names of the internal nets of aud_ring_dma.
module aud_ring_dma_chk
    import aud_dma_pkg::*;
#(
    parameter int CW = 26
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    reg_wr,
    input logic [4:0]              reg_addr,
    input logic [31:0]             reg_wdata,
    input logic [NEV-1:0]          evt,
    input logic [NEV-1:0]          status,
    input logic [DIRS-1:0]         en,
    input logic [DIRS-1:0]         auto_rl,
    input logic [DIRS-1:0][CW-1:0] prog,
    input logic [DIRS-1:0]         hit_full,
    input logic                    txf_push,
    input logic                    rxf_pop
);
    for (genvar i = 0; i < NEV; i++) begin : g_ev
        AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |-> status[i]); // R10
    end

    AST_PUSH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        txf_push |-> en[0]); // R4

    AST_POP_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_pop |-> en[1]); // R5

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_CTRL && reg_wdata[BIT_STOP])
        |=> (!en[0] && prog[0] == '0)); // R9

    AST_ONESHOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_full[1] && !auto_rl[1] && !(reg_wr && reg_addr == OFS_CTRL))
        |=> (!en[1] && prog[1] == '0)); // R8

    AST_RELOAD_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_full[0] && auto_rl[0] && !(reg_wr && reg_addr == OFS_CTRL))
        |=> (en[0] && prog[0] == '0)); // R7
endmodule

bind aud_ring_dma aud_ring_dma_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .evt(evt), .status(status), .en(en),
    .auto_rl(auto_rl), .prog(prog), .hit_full(hit_full),
    .txf_push(txf_push), .rxf_pop(rxf_pop)
);

// File: tb/aud_ring_dma_test.sv
// Scoreboard bench: driver tasks queue expected transfers, monitor compares.
module aud_ring_dma_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pb_req, pb_gnt, txf_push, rc_req, rc_gnt, rxf_pop;
    logic [31:0] pb_addr, pb_rdata, txf_data, rc_addr, rc_wdata, rxf_data;
    logic        txf_ready = 1'b1;
    logic        rxf_valid = 1'b1;
    logic [3:0]  evt;
    logic [1:0]  gnt_en = '0;
    logic [31:0] rx_seq;

    int errors = 0;
    int checks = 0;
    logic [31:0] q_pb[$];
    logic [31:0] q_ra[$];
    logic [31:0] q_rd[$];
    int evt_cnt[4] = '{0, 0, 0, 0};
    int exp_evt[4] = '{0, 0, 0, 0};
    logic [31:0] m_base[2];
    logic [31:0] m_len[2];
    logic [31:0] m_pos[2];
    logic [31:0] m_seq = 32'hC0DE0000;

    always #2 clk = ~clk;

    aud_ring_dma uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pb_req(pb_req),
        .pb_addr(pb_addr), .pb_gnt(pb_gnt), .pb_rdata(pb_rdata),
        .txf_ready(txf_ready), .txf_push(txf_push), .txf_data(txf_data),
        .rc_req(rc_req), .rc_addr(rc_addr), .rc_wdata(rc_wdata),
        .rc_gnt(rc_gnt), .rxf_valid(rxf_valid), .rxf_data(rxf_data),
        .rxf_pop(rxf_pop), .evt(evt)
    );

    // Memory and FIFO models
    assign pb_gnt   = pb_req & gnt_en[0];
    assign rc_gnt   = rc_req & gnt_en[1];
    assign pb_rdata = pb_addr ^ 32'h5A5A0000;
    assign rxf_data = rx_seq;
    always @(posedge clk) begin
        if (!rst_n)       rx_seq <= 32'hC0DE0000;
        else if (rxf_pop) rx_seq <= rx_seq + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pop expected items as transfers and events appear
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 4; i++) if (evt[i]) evt_cnt[i]++;
            if (txf_push) begin
                if (q_pb.size() == 0) chk("R4 unexpected push", txf_data, 32'hx);
                else chk("R4 push data", txf_data, q_pb.pop_front());
            end
            if (rxf_pop) begin
                if (q_ra.size() == 0) chk("R5 unexpected store", rc_addr, 32'hx);
                else begin
                    chk("R5 store addr", rc_addr, q_ra.pop_front());
                    chk("R5 store data", rc_wdata, q_rd.pop_front());
                end
            end
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; #1;
        d = reg_rdata;
    endtask

    // Driver model: queue expected words and events for n transfers
    task automatic expect_beats(input int d, input int n);
        for (int k = 0; k < n; k++) begin
            logic [31:0] a;
            logic [31:0] np;
            a = m_base[d] + m_pos[d];
            if (d == 0) q_pb.push_back(a ^ 32'h5A5A0000);
            else begin
                q_ra.push_back(a); q_rd.push_back(m_seq); m_seq++;
            end
            np = m_pos[d] + 4;
            if (m_pos[d] < (m_len[d] >> 1) && np >= (m_len[d] >> 1)) exp_evt[2*d]++;
            if (np >= m_len[d]) begin exp_evt[2*d+1]++; np = 0; end
            m_pos[d] = np;
        end
    endtask

    task automatic grant(input int d, input int n);
        expect_beats(d, n);
        @(posedge clk); #1;
        gnt_en[d] = 1'b1;
        repeat (n) @(posedge clk);
        #1 gnt_en[d] = 1'b0;
    endtask

    task automatic chk_evts(input string tag);
        repeat (2) @(posedge clk);
        for (int i = 0; i < 4; i++) chk(tag, 32'(evt_cnt[i]), 32'(exp_evt[i]));
    endtask

    logic done = 1'b0;
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        m_pos = '{0, 0};
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 32; a += 4) begin
            rd(5'(a), v); chk("R1 reset reg", v, 32'h0);
        end
        chk("R1 no request", {30'h0, pb_req, rc_req}, 32'h0);
        chk("R1 no event", {28'h0, evt}, 32'h0);

        // R2: length and base masking
        wr(5'h08, 32'hFFFFFFFF); rd(5'h08, v); chk("R2 len mask", v, 32'h03FFFFFC);
        wr(5'h04, 32'h00002003); rd(5'h04, v); chk("R2 base mask", v, 32'h00002000);
        // R3: alignment readback, stop reads 0, stop beats enable
        wr(5'h10, 32'h01020203); rd(5'h10, v); chk("R3 ctrl readback", v, 32'h01000200);
        chk("R9 stop over enable", {31'h0, pb_req}, 32'h0);

        // Playback one-shot: base 0x1000, len 16
        m_base[0] = 32'h1000; m_len[0] = 16; m_pos[0] = 0;
        wr(5'h00, 32'h1000); wr(5'h08, 32'd16); wr(5'h10, 32'h1);
        chk("R4 req addr", pb_addr, 32'h1000);
        chk("R4 req high", {31'h0, pb_req}, 32'h1);
        grant(0, 3);
        rd(5'h14, v); chk("R4 progress", v, 32'd12);
        chk_evts("R6 half only");
        grant(0, 1);
        chk_evts("R6 half and full");
        rd(5'h10, v); chk("R8 enable cleared", v, 32'h0);
        rd(5'h14, v); chk("R8 progress zero", v, 32'h0);
        chk("R8 req low", {31'h0, pb_req}, 32'h0);
        rd(5'h1C, v); chk("R10 status set", v, 32'h3);
        wr(5'h1C, 32'h1); rd(5'h1C, v); chk("R10 w1c single", v, 32'h2);
        wr(5'h1C, 32'hF); rd(5'h1C, v); chk("R10 w1c all", v, 32'h0);

        // Record one-shot: base 0x2000, len 12
        m_base[1] = 32'h2000; m_len[1] = 12; m_pos[1] = 0;
        wr(5'h0C, 32'd12); wr(5'h10, 32'h10000);
        chk("R5 req addr", rc_addr, 32'h2000);
        grant(1, 3);
        chk_evts("R6 record events");
        rd(5'h10, v); chk("R8 record stopped", v, 32'h0);
        rd(5'h1C, v); chk("R10 record status", v, 32'hC);
        wr(5'h1C, 32'hF);

        // R7: playback auto-reload over a length of 8
        m_len[0] = 8; m_pos[0] = 0;
        wr(5'h08, 32'd8); wr(5'h10, 32'h5);
        grant(0, 5);
        chk_evts("R7 wrap events");
        rd(5'h14, v); chk("R7 progress after wrap", v, 32'd4);
        rd(5'h10, v); chk("R7 still enabled", v, 32'h5);
        chk("R7 addr after wrap", pb_addr, 32'h1004);

        // R9: forced stop mid-ring
        wr(5'h10, 32'h2); m_pos[0] = 0;
        rd(5'h10, v); chk("R9 stop clears enable", v, 32'h0);
        rd(5'h14, v); chk("R9 stop clears progress", v, 32'h0);
        wr(5'h1C, 32'hF);

        // R11 and R10: both halves cross while status is being cleared
        m_len[1] = 8; m_pos[1] = 0;
        wr(5'h0C, 32'd8); wr(5'h10, 32'h00050005);
        expect_beats(0, 1); expect_beats(1, 1);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = 5'h1C; reg_wdata = 32'hF; gnt_en = 2'b11;
        @(posedge clk); #1;
        reg_wr = 1'b0; gnt_en = 2'b00;
        rd(5'h1C, v); chk("R10 event beats clear", v, 32'h5);
        chk_evts("R11 both halves");
        rd(5'h18, v); chk("R11 record progress", v, 32'd4);
        wr(5'h10, 32'h00020002);
        rd(5'h10, v); chk("R9 both stopped", v, 32'h0);
        chk("R4 queue drained", 32'(q_pb.size() + q_ra.size()), 32'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule